// File: doc/BRIEF.md
# Multi-gigabit link transmit sequencer

This block drives one transmit lane of a JESD204B-style serial link at the data-link level. On each link clock it emits one 32-bit lane word, which holds four octets, together with a 4-bit flag that marks the octets that are control characters. While the far-end receiver holds its active-low synchronization request, the lane sends only comma characters. After the receiver releases the request, the lane keeps sending commas for a guaranteed minimum stretch and then waits for a multiframe boundary strobe.

At that boundary the block plays the initial lane alignment sequence. This sequence is four multiframes long, and each multiframe is framed by start and end markers. The second multiframe carries a configuration marker followed by fourteen link configuration octets. After the sequence the lane passes user payload words straight through.

If the receiver asserts the synchronization request again during alignment or user data, the link falls back to commas and flags an error. The frame size and the number of frames per multiframe are parameters. Encoding, serialization, scrambling and sample mapping are handled by neighbouring blocks.

Top module: `lane_link_sequencer`

## Requirements
- R1: When `sync_req_n` is sampled low at a clock edge, the lane word registered at that edge is 0xBCBCBCBC and `lane_ctrl` is 4'b1111.
- R2: The octet sent first in time sits in `lane_word[7:0]`, the last in `lane_word[31:24]`. Bit j of `lane_ctrl` belongs to the octet in `lane_word[8j+7:8j]`.
- R3: A `lane_ctrl` bit is 1 only for the control codes 0xBC, 0x1C, 0x9C and 0x7C. It is 0 for configuration, filler and payload octets.
- R4: After `sync_req_n` is sampled high, commas continue for at least ceil((F+9)/4) words. An `mf_tick` sampled before that many comma words have been registered is ignored. The first `mf_tick` sampled after that point makes the next registered word the first alignment word.
- R5: The alignment sequence is exactly 4 multiframes of F×K octets. Octet 0 of each multiframe is 0x1C and the last octet is 0x7C, both flagged.
- R6: In the second multiframe, octet 1 is 0x9C (flagged) and octets 2..15 carry configuration octets 0..13, taken from `cfg_octets[8i+7:8i]` for octet i.
- R7: Every other alignment octet carries its own octet index within the multiframe, modulo 256, unflagged.
- R8: The word after the last alignment word is `user_word` as sampled at that edge, with `lane_ctrl` = 0. Payload then follows each cycle, and `mf_tick` has no effect during alignment or payload.
- R9: `sync_req_n` sampled low during alignment or payload sends commas from the next word and raises `link_err` for exactly one cycle. A request during the post-release comma stretch raises no error.
- R10: During reset the lane sends commas with all flags set and `link_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one lane word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req_n | input | 1 | Receiver synchronization request, active low |
| mf_tick | input | 1 | Multiframe boundary strobe: the word registered at this edge may begin a multiframe |
| cfg_octets | input | 112 | Fourteen link configuration octets, octet i at bits [8i+7:8i] |
| user_word | input | 32 | Payload word, four octets |
| lane_word | output | 32 | Lane word toward the encoder |
| lane_ctrl | output | 4 | Per-octet control-character flags |
| link_err | output | 1 | One-cycle pulse on a synchronization request outside the comma phases |

## Verification
The bench builds the sequencer with one-octet frames and 32 frames per multiframe. This gives 8-word multiframes and a 32-word alignment sequence, so every alignment word can be walked and checked against a table. It also sets the minimum comma stretch to three words. That makes the cut-off between an ignored early boundary strobe and an accepted one reachable within a few cycles. The same setting keeps the abort paths short: a request during the comma stretch, during alignment and during payload.

// File: rtl/lnk_seq_pkg.sv
package lnk_seq_pkg;

  typedef enum logic [1:0] {
    ST_CGS  = 2'd0,
    ST_HOLD = 2'd1,
    ST_ILAS = 2'd2,
    ST_DATA = 2'd3
  } lnk_state_e;

  localparam logic [7:0] CH_COMMA    = 8'hBC;
  localparam logic [7:0] CH_MF_START = 8'h1C;
  localparam logic [7:0] CH_CFG_MARK = 8'h9C;
  localparam logic [7:0] CH_MF_END   = 8'h7C;

  localparam int OCTS_PER_WORD = 4;
  localparam int CFG_OCTETS    = 14;
  localparam int ILAS_MFRAMES  = 4;

endpackage

// File: rtl/lnk_rst_sync.sv
module lnk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/lnk_seq_ctrl.sv
module lnk_seq_ctrl
  import lnk_seq_pkg::*;
#(
  parameter int OCTETS_PER_FRAME = 4,
  parameter int FRAMES_PER_MF    = 32,
  localparam int WORDS_PER_MF    = OCTETS_PER_FRAME * FRAMES_PER_MF / OCTS_PER_WORD,
  localparam int ILAS_WORDS      = ILAS_MFRAMES * WORDS_PER_MF,
  localparam int WC_W            = $clog2(ILAS_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req_n,
  input  logic             mf_tick,
  output lnk_state_e       st_d,
  output logic [WC_W-1:0]  wcnt_d,
  output logic             err_d
);
  localparam int MIN_K_WORDS = (OCTETS_PER_FRAME + 9 + OCTS_PER_WORD - 1) / OCTS_PER_WORD;
  localparam int KC_W        = $clog2(MIN_K_WORDS + 1);
  localparam logic [KC_W-1:0] K_MIN_V   = KC_W'(MIN_K_WORDS);
  localparam logic [KC_W-1:0] K_ONE_V   = KC_W'(1);
  localparam logic [WC_W-1:0] ILAS_LAST = WC_W'(ILAS_WORDS - 1);

  lnk_state_e       st_q;
  logic [WC_W-1:0]  wcnt_q;
  logic [KC_W-1:0]  kcnt_q, kcnt_d;
  logic             wcnt_en, kcnt_en;

  // next-state decode
  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    kcnt_d = kcnt_q;
    err_d  = 1'b0;
    if (!sync_req_n) begin
      st_d   = ST_CGS;
      wcnt_d = '0;
      kcnt_d = '0;
      err_d  = (st_q == ST_ILAS) || (st_q == ST_DATA);
    end else begin
      unique case (st_q)
        ST_CGS: begin
          st_d   = ST_HOLD;
          kcnt_d = K_ONE_V;
        end
        ST_HOLD: begin
          if (mf_tick && (kcnt_q >= K_MIN_V)) begin
            st_d   = ST_ILAS;
            wcnt_d = '0;
          end else if (kcnt_q < K_MIN_V) begin
            kcnt_d = kcnt_q + K_ONE_V;
          end
        end
        ST_ILAS: begin
          if (wcnt_q == ILAS_LAST) st_d = ST_DATA;
          else                     wcnt_d = wcnt_q + WC_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign wcnt_en = (wcnt_d != wcnt_q);
  assign kcnt_en = (kcnt_d != kcnt_q);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CGS;
      wcnt_q <= '0;
      kcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
      if (kcnt_en) kcnt_q <= kcnt_d;
    end
  end
endmodule

// File: rtl/ilas_word_gen.sv
module ilas_word_gen
  import lnk_seq_pkg::*;
#(
  parameter int OCTETS_PER_FRAME = 4,
  parameter int FRAMES_PER_MF    = 32,
  localparam int MF_OCTETS       = OCTETS_PER_FRAME * FRAMES_PER_MF,
  localparam int WORDS_PER_MF    = MF_OCTETS / OCTS_PER_WORD,
  localparam int ILAS_WORDS      = ILAS_MFRAMES * WORDS_PER_MF,
  localparam int WC_W            = $clog2(ILAS_WORDS),
  localparam int WPOS_W          = $clog2(WORDS_PER_MF),
  localparam int OCT_W           = WPOS_W + 2
) (
  input  logic [WC_W-1:0]              wcnt,
  input  logic [8*CFG_OCTETS-1:0]      cfg_octets,
  output logic [8*OCTS_PER_WORD-1:0]   word,
  output logic [OCTS_PER_WORD-1:0]     ctrl
);
  localparam logic [OCT_W-1:0] OCT_LAST    = OCT_W'(MF_OCTETS - 1);
  localparam logic [OCT_W-1:0] OCT_CFG_LO  = OCT_W'(2);
  localparam logic [OCT_W-1:0] OCT_CFG_END = OCT_W'(2 + CFG_OCTETS);

  logic [1:0]        mf_idx;
  logic [WPOS_W-1:0] wpos;
  logic [7:0]        cfg_arr [16];

  assign mf_idx = wcnt[WC_W-1 -: 2];
  assign wpos   = wcnt[WPOS_W-1:0];

  for (genvar c = 0; c < 16; c++) begin : g_cfg
    if (c < CFG_OCTETS) begin : g_real
      assign cfg_arr[c] = cfg_octets[8*c +: 8];
    end else begin : g_pad
      assign cfg_arr[c] = 8'h00;
    end
  end

  for (genvar j = 0; j < OCTS_PER_WORD; j++) begin : g_oct
    logic [OCT_W-1:0] oct;
    logic [3:0]       cidx;
    logic [7:0]       val;
    logic             is_k;

    assign oct  = {wpos, 2'(j)};
    assign cidx = 4'(oct - OCT_CFG_LO);

    always_comb begin
      val  = 8'(oct);
      is_k = 1'b0;
      if (oct == '0) begin
        val  = CH_MF_START;
        is_k = 1'b1;
      end else if (oct == OCT_LAST) begin
        val  = CH_MF_END;
        is_k = 1'b1;
      end else if (mf_idx == 2'd1) begin
        if (oct == OCT_W'(1)) begin
          val  = CH_CFG_MARK;
          is_k = 1'b1;
        end else if ((oct >= OCT_CFG_LO) && (oct < OCT_CFG_END)) begin
          val  = cfg_arr[cidx];
        end
      end
    end

    assign word[8*j +: 8] = val;
    assign ctrl[j]        = is_k;
  end
endmodule

// File: rtl/lane_link_sequencer.sv
module lane_link_sequencer
  import lnk_seq_pkg::*;
#(
  parameter int OCTETS_PER_FRAME = 4,
  parameter int FRAMES_PER_MF    = 32,
  localparam int WORDS_PER_MF    = OCTETS_PER_FRAME * FRAMES_PER_MF / OCTS_PER_WORD,
  localparam int WC_W            = $clog2(ILAS_MFRAMES * WORDS_PER_MF)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_req_n,
  input  logic         mf_tick,
  input  logic [111:0] cfg_octets,
  input  logic [31:0]  user_word,
  output logic [31:0]  lane_word,
  output logic [3:0]   lane_ctrl,
  output logic         link_err
);
  logic             rst_n_i;
  lnk_state_e       st_d;
  logic [WC_W-1:0]  wcnt_d;
  logic             err_d;
  logic [31:0]      ilas_word, word_d, word_q;
  logic [3:0]       ilas_ctrl, ctrl_d, ctrl_q;
  logic             err_q;

  lnk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  lnk_seq_ctrl #(
    .OCTETS_PER_FRAME (OCTETS_PER_FRAME),
    .FRAMES_PER_MF    (FRAMES_PER_MF)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .sync_req_n (sync_req_n),
    .mf_tick    (mf_tick),
    .st_d       (st_d),
    .wcnt_d     (wcnt_d),
    .err_d      (err_d)
  );

  ilas_word_gen #(
    .OCTETS_PER_FRAME (OCTETS_PER_FRAME),
    .FRAMES_PER_MF    (FRAMES_PER_MF)
  ) u_gen (
    .wcnt       (wcnt_d),
    .cfg_octets (cfg_octets),
    .word       (ilas_word),
    .ctrl       (ilas_ctrl)
  );

  // output select from the next state
  always_comb begin
    unique case (st_d)
      ST_ILAS: begin
        word_d = ilas_word;
        ctrl_d = ilas_ctrl;
      end
      ST_DATA: begin
        word_d = user_word;
        ctrl_d = 4'h0;
      end
      default: begin
        word_d = {4{CH_COMMA}};
        ctrl_d = 4'hF;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      word_q <= {4{CH_COMMA}};
      ctrl_q <= 4'hF;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  assign lane_word = word_q;
  assign lane_ctrl = ctrl_q;
  assign link_err  = err_q;
endmodule

// File: rtl/lane_link_sequencer_chk.sv
module lane_link_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sync_req_n,
  input logic [31:0] lane_word,
  input logic [3:0]  lane_ctrl,
  input logic        link_err
);
  function automatic bit flags_ok(logic [31:0] w, logic [3:0] f);
    bit ok = 1'b1;
    for (int j = 0; j < 4; j++) begin
      if (f[j] && !(w[8*j +: 8] inside {8'hBC, 8'h1C, 8'h9C, 8'h7C})) ok = 1'b0;
    end
    return ok;
  endfunction

  // R1
  comma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req_n |=> (lane_word == 32'hBCBCBCBC) && (lane_ctrl == 4'hF));

  // R3
  ctrl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_ok(lane_word, lane_ctrl));

  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |=> !link_err);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |-> $past(!sync_req_n));

  // R9
  err_commas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |-> (lane_word == 32'hBCBCBCBC) && (lane_ctrl == 4'hF));
endmodule

bind lane_link_sequencer lane_link_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_req_n (sync_req_n),
  .lane_word  (lane_word),
  .lane_ctrl  (lane_ctrl),
  .link_err   (link_err)
);

// File: tb/tb_lane_link_sequencer.sv
module tb_lane_link_sequencer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         sync_req_n;
  logic         mf_tick;
  logic [111:0] cfg_octets;
  logic [31:0]  user_word;
  logic [31:0]  lane_word;
  logic [3:0]   lane_ctrl;
  logic         link_err;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lane_link_sequencer #(.OCTETS_PER_FRAME(1), .FRAMES_PER_MF(32)) dut (
    .clk (clk), .rst_n (rst_n), .sync_req_n (sync_req_n), .mf_tick (mf_tick),
    .cfg_octets (cfg_octets), .user_word (user_word),
    .lane_word (lane_word), .lane_ctrl (lane_ctrl), .link_err (link_err)
  );

  // {alignment word index, expected word, expected flags}; F=1, K=32, cfg octet i = 0xA0+i
  localparam logic [43:0] ILAS_TAB [12] = '{
    {8'd0,  32'h0302011C, 4'h1},
    {8'd1,  32'h07060504, 4'h0},
    {8'd7,  32'h7C1E1D1C, 4'h8},
    {8'd8,  32'hA1A09C1C, 4'h3},
    {8'd9,  32'hA5A4A3A2, 4'h0},
    {8'd10, 32'hA9A8A7A6, 4'h0},
    {8'd11, 32'hADACABAA, 4'h0},
    {8'd12, 32'h13121110, 4'h0},
    {8'd15, 32'h7C1E1D1C, 4'h8},
    {8'd16, 32'h0302011C, 4'h1},
    {8'd24, 32'h0302011C, 4'h1},
    {8'd31, 32'h7C1E1D1C, 4'h8}
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_commas(string req, logic err_exp);
    check(req, lane_word, 32'hBCBCBCBC);
    check(req, {28'd0, lane_ctrl}, 32'hF);
    check(req, {31'd0, link_err}, {31'd0, err_exp});
  endtask

  function automatic bit flag_codes_ok(logic [31:0] w, logic [3:0] f);
    for (int j = 0; j < 4; j++)
      if (f[j] && !(w[8*j +: 8] inside {8'hBC, 8'h1C, 8'h9C, 8'h7C})) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_req_n = 1'b0; mf_tick = 1'b0; user_word = '0;
    for (int i = 0; i < 14; i++) cfg_octets[8*i +: 8] = 8'hA0 + 8'(i);
    repeat (3) step();
    check_commas("R10 reset", 1'b0);
    rst_n = 1'b1;
    repeat (4) step();
    check_commas("R1 sync held", 1'b0);

    // release; early ticks ignored until three comma words passed
    sync_req_n = 1'b1;
    step(); check_commas("R4 after release", 1'b0);
    step(); check_commas("R4 second word", 1'b0);
    mf_tick = 1'b1;
    step(); check_commas("R4 early tick ignored", 1'b0);
    step();
    // alignment sequence walk, tick held high to show it is ignored (R8)
    for (int w = 0; w < 32; w++) begin
      for (int t = 0; t < 12; t++) begin
        if (int'(ILAS_TAB[t][43:36]) == w) begin
          check($sformatf("R5/R6/R7 word %0d", w), lane_word, ILAS_TAB[t][35:4]);
          check($sformatf("R2/R3 flags %0d", w), {28'd0, lane_ctrl}, {28'd0, ILAS_TAB[t][3:0]});
        end
      end
      check("R3 flag codes", {31'd0, flag_codes_ok(lane_word, lane_ctrl)}, 32'd1);
      if (w == 31) user_word = 32'h11223344;
      step();
    end
    check("R8 first payload", lane_word, 32'h11223344);
    check("R8 payload flags", {28'd0, lane_ctrl}, 32'h0);
    for (int i = 0; i < 5; i++) begin
      user_word = 32'hBC1C9C7C ^ (32'h01010101 * (i + 1));
      mf_tick = i[0];
      step();
      check("R8 payload pass", lane_word, 32'hBC1C9C7C ^ (32'h01010101 * (i + 1)));
      check("R8 payload flags", {28'd0, lane_ctrl}, 32'h0);
    end

    // request during payload
    sync_req_n = 1'b0;
    step(); check_commas("R9 resync in data", 1'b1);
    step(); check_commas("R9 err one cycle", 1'b0);

    // request during comma stretch: no error
    sync_req_n = 1'b1;
    step();
    sync_req_n = 1'b0;
    step(); check_commas("R9 resync in hold", 1'b0);

    // new alignment, aborted mid-sequence
    sync_req_n = 1'b1; mf_tick = 1'b1;
    repeat (4) step();
    check("R4 tick accepted", lane_word, 32'h0302011C);
    repeat (5) step();
    check("R7 filler", lane_word, 32'h17161514);
    sync_req_n = 1'b0;
    step(); check_commas("R9 resync in alignment", 1'b1);
    step(); check_commas("R9 err cleared", 1'b0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule